// File: doc/BRIEF.md
# PWM Carrier Chopper

This block turns a slow PWM signal into a burst of high-frequency pulses, which is the form an isolation transformer needs to carry a gate drive signal. While the PWM input is high and chopping is enabled, the output starts with one wide pulse of programmable length. A train of short carrier pulses with a programmable duty follows it. While the PWM input is low, the output is low. With chopping disabled, the block passes the PWM through with one register of delay.

The carrier runs from the block's own clock. It does not depend on any PWM timer, so a level that software forces onto the PWM input is chopped in the same way as a timer-generated waveform. A carrier tick lasts a programmable number of clock cycles (the prescale). Eight ticks form one carrier period. The duty is the number of high ticks at the start of each period. The first pulse lasts a whole number of carrier periods.

Configuration is copied into internal shadow registers in two cases: on every cycle in which the PWM input is low, and at the last cycle of each carrier period. A setting written in the middle of a period therefore never cuts a pulse short and never lengthens one.

Top module: `pwm_chopper`

## Requirements
- R1: While rst_n is low, pwmOut is low and all counters are cleared. After reset, the shadow configuration is: chopping disabled, prescale 1, duty 0, first-pulse width 1.
- R2: With chopping disabled (shadow enable 0), pwmOut after each clock edge equals the pwmIn value sampled at that edge.
- R3: With chopping enabled, number the edges from the first edge at which pwmIn is sampled high (n = 0). Let P be the prescale, k = n / P the tick index, m = k / 8 the period index and t = k mod 8 the tick within the period. After edge n, pwmOut is 1 if m < F. Otherwise pwmOut is 1 exactly when t < D.
- R4: cfgPrescale (5 bits, unsigned) is used as P after sanitising: 0 acts as 1, and any value above 16 acts as 16.
- R5: cfgDuty (3 bits, unsigned) is D, the number of high ticks per carrier period. D = 0 holds pwmOut low once the first pulse has ended, and D = 7 gives 7 high ticks out of 8.
- R6: cfgFirst (5 bits, unsigned) is F, the first-pulse width in whole carrier periods. 0 acts as 1, and any value above 16 acts as 16.
- R7: When pwmIn is sampled low, pwmOut is low after that edge. This holds in the middle of the first pulse as well.
- R8: Every rising phase of pwmIn restarts the carrier at n = 0, even after a low gap of a single cycle.
- R9: The configuration inputs are captured at edges where pwmIn is sampled low, or at the edge that closes a carrier period. A change made in the middle of a period takes effect from the first tick of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | 1 enables chopping, 0 passes the PWM through |
| cfgPrescale | input | 5 | Clock cycles per carrier tick (1 to 16) |
| cfgDuty | input | 3 | High ticks per 8-tick carrier period |
| cfgFirst | input | 5 | First-pulse width in carrier periods (1 to 16) |
| pwmIn | input | 1 | PWM input to be chopped |
| pwmOut | output | 1 | Chopped or passed-through PWM output |

## Verification
In one cycle, the shadow reload at the end of a carrier period and a new configuration write on the inputs can both occur. The bench changes the duty in the middle of a carrier period while the PWM is high. It then checks every cycle: the old duty must shape the rest of that period, and the new duty must apply from the first tick of the following period. A fall of the PWM input during the first pulse, and a rise after a single-cycle low gap, are also driven. In these cases the output is judged against the formula of R3 counted from the new rising phase.

// File: rtl/pwm_chopper_pkg.sv
package pwm_chopper_pkg;

  // Strobes from the phase control to the shadow registers and the datapath.
  typedef struct packed {
    logic hold;       // PWM input low: counters parked at phase zero
    logic periodEnd;  // last clock cycle of a carrier period
  } chop_strobe_t;

endpackage

// File: rtl/pwm_chopper_cfg.sv
module pwm_chopper_cfg
  import pwm_chopper_pkg::*;
#(
  parameter int PRE_MAX   = 16,
  parameter int FIRST_MAX = 16,
  parameter int DUTY_W    = 3,
  localparam int PRE_W    = $clog2(PRE_MAX + 1),
  localparam int FIRST_W  = $clog2(FIRST_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgEnable,
  input  logic [PRE_W-1:0]   cfgPrescale,
  input  logic [DUTY_W-1:0]  cfgDuty,
  input  logic [FIRST_W-1:0] cfgFirst,
  input  chop_strobe_t       strb,
  output logic               shEnable,
  output logic [PRE_W-1:0]   shPre,
  output logic [DUTY_W-1:0]  shDuty,
  output logic [FIRST_W-1:0] shFirst
);

  localparam logic [PRE_W-1:0]   PRE_CAP   = PRE_W'(PRE_MAX);
  localparam logic [FIRST_W-1:0] FIRST_CAP = FIRST_W'(FIRST_MAX);

  logic               loadCfg;
  logic [PRE_W-1:0]   preFit;
  logic [FIRST_W-1:0] firstFit;

  // Clamp illegal settings into the legal range: zero -> 1, above max -> max
  always_comb begin
    if (cfgPrescale == '0)          preFit = PRE_W'(1);
    else if (cfgPrescale > PRE_CAP) preFit = PRE_CAP;
    else                            preFit = cfgPrescale;

    if (cfgFirst == '0)             firstFit = FIRST_W'(1);
    else if (cfgFirst > FIRST_CAP)  firstFit = FIRST_CAP;
    else                            firstFit = cfgFirst;
  end

  // Capture only while idle or on a period boundary, so no runt pulses
  assign loadCfg = strb.hold | strb.periodEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shEnable <= 1'b0;
      shPre    <= PRE_W'(1);
      shDuty   <= '0;
      shFirst  <= FIRST_W'(1);
    end else if (loadCfg) begin
      shEnable <= cfgEnable;
      shPre    <= preFit;
      shDuty   <= cfgDuty;
      shFirst  <= firstFit;
    end
  end

  // R9: no shadow change inside a carrier period while the PWM is high
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.hold && !strb.periodEnd) |=>
      ($stable(shEnable) && $stable(shPre) && $stable(shDuty) && $stable(shFirst)));

  // R4 / R6: shadow values always legal
  p_shadow_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shPre != '0) && (shPre <= PRE_CAP) && (shFirst != '0) && (shFirst <= FIRST_CAP));

endmodule

// File: rtl/pwm_chopper_ctrl.sv
module pwm_chopper_ctrl
  import pwm_chopper_pkg::*;
#(
  parameter int PRE_MAX  = 16,
  parameter int DUTY_W   = 3,
  localparam int PRE_W   = $clog2(PRE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwmIn,
  input  logic [PRE_W-1:0]  shPre,
  output chop_strobe_t      strb,
  output logic [DUTY_W-1:0] tickIdx
);

  logic [PRE_W-1:0]  preCnt;
  logic [DUTY_W-1:0] tickCnt;
  logic              tickEnd;
  logic [PRE_W-1:0]  preLast;

  assign preLast        = shPre - PRE_W'(1);
  assign tickEnd        = (preCnt == preLast);
  assign strb.hold      = ~pwmIn;
  assign strb.periodEnd = pwmIn & tickEnd & (tickCnt == '1);
  assign tickIdx        = tickCnt;

  // Phase counters: parked at zero while the PWM is low, so every rising
  // phase starts from tick 0 of period 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (!pwmIn) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tickEnd) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + DUTY_W'(1);
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end

  // R3: the prescale counter never passes the active prescale
  p_prescale_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt < shPre);

  // R8: a low PWM sample parks the phase at zero
  p_phase_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwmIn |=> (preCnt == '0 && tickCnt == '0));

endmodule

// File: rtl/pwm_chopper_dp.sv
module pwm_chopper_dp
  import pwm_chopper_pkg::*;
#(
  parameter int FIRST_MAX = 16,
  parameter int DUTY_W    = 3,
  localparam int FIRST_W  = $clog2(FIRST_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwmIn,
  input  chop_strobe_t       strb,
  input  logic [DUTY_W-1:0]  tickIdx,
  input  logic               shEnable,
  input  logic [DUTY_W-1:0]  shDuty,
  input  logic [FIRST_W-1:0] shFirst,
  output logic               pwmOut
);

  localparam logic [FIRST_W-1:0] FIRST_CAP = FIRST_W'(FIRST_MAX);

  logic [FIRST_W-1:0] perCnt;
  logic               inFirst;
  logic               carrierLvl;
  logic               outNext;

  assign inFirst    = (perCnt < shFirst);
  assign carrierLvl = inFirst | (tickIdx < shDuty);
  assign outNext    = pwmIn & (shEnable ? carrierLvl : 1'b1);

  // Completed-period counter, saturating once past any legal first width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perCnt <= '0;
    end else if (strb.hold) begin
      perCnt <= '0;
    end else if (strb.periodEnd && perCnt < FIRST_CAP) begin
      perCnt <= perCnt + FIRST_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwmOut <= 1'b0;
    else        pwmOut <= outNext;
  end

  // R7: low input forces low output on the next cycle
  p_low_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwmIn |=> !pwmOut);

  // R2: bypass follows the input
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shEnable |=> (pwmOut == $past(pwmIn)));

  // R6: during the first pulse the output stays high
  p_first_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shEnable && pwmIn && perCnt < shFirst) |=> pwmOut);

  // R5: zero duty keeps the output low after the first pulse
  p_duty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shEnable && pwmIn && perCnt >= shFirst && shDuty == '0) |=> !pwmOut);

  // R6: period counter bounded
  p_period_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    perCnt <= FIRST_CAP);

endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import pwm_chopper_pkg::*;
#(
  parameter int PRE_MAX   = 16,
  parameter int FIRST_MAX = 16,
  parameter int DUTY_W    = 3,
  localparam int PRE_W    = $clog2(PRE_MAX + 1),
  localparam int FIRST_W  = $clog2(FIRST_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgEnable,
  input  logic [PRE_W-1:0]   cfgPrescale,
  input  logic [DUTY_W-1:0]  cfgDuty,
  input  logic [FIRST_W-1:0] cfgFirst,
  input  logic               pwmIn,
  output logic               pwmOut
);

  chop_strobe_t       strb;
  logic [DUTY_W-1:0]  tickIdx;
  logic               shEnable;
  logic [PRE_W-1:0]   shPre;
  logic [DUTY_W-1:0]  shDuty;
  logic [FIRST_W-1:0] shFirst;

  pwm_chopper_cfg #(
    .PRE_MAX(PRE_MAX), .FIRST_MAX(FIRST_MAX), .DUTY_W(DUTY_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfgEnable(cfgEnable), .cfgPrescale(cfgPrescale),
    .cfgDuty(cfgDuty), .cfgFirst(cfgFirst),
    .strb(strb),
    .shEnable(shEnable), .shPre(shPre), .shDuty(shDuty), .shFirst(shFirst)
  );

  pwm_chopper_ctrl #(
    .PRE_MAX(PRE_MAX), .DUTY_W(DUTY_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .shPre(shPre),
    .strb(strb), .tickIdx(tickIdx)
  );

  pwm_chopper_dp #(
    .FIRST_MAX(FIRST_MAX), .DUTY_W(DUTY_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .strb(strb), .tickIdx(tickIdx),
    .shEnable(shEnable), .shDuty(shDuty), .shFirst(shFirst),
    .pwmOut(pwmOut)
  );

endmodule

// File: tb/pwm_chopper_bench.sv
`timescale 1ns/1ps
module pwm_chopper_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgEnable = 1'b0;
  logic [4:0] cfgPrescale = 5'd1;
  logic [2:0] cfgDuty = 3'd0;
  logic [4:0] cfgFirst = 5'd1;
  logic       pwmIn = 1'b0;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pwm_chopper u_pwm_chopper (
    .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .cfgPrescale(cfgPrescale),
    .cfgDuty(cfgDuty), .cfgFirst(cfgFirst), .pwmIn(pwmIn), .pwmOut(pwmOut)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pwmOut=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected level after edge n of a high phase (R3)
  function automatic logic lvl(input int n, input int p, input int f, input int d);
    int k = n / p;
    if ((k / 8) < f) return 1'b1;
    return ((k % 8) < d);
  endfunction

  task automatic setCfg(input logic en, input int pre, input int duty, input int first);
    @(negedge clk);
    pwmIn       = 1'b0;
    cfgEnable   = en;
    cfgPrescale = 5'(pre);
    cfgDuty     = 3'(duty);
    cfgFirst    = 5'(first);
    repeat (2) @(negedge clk);
  endtask

  task automatic runHigh(input string tag, input int cnt, input int p, input int f, input int d);
    pwmIn = 1'b1;
    for (int n = 0; n < cnt; n++) begin
      @(negedge clk);
      chk(tag, pwmOut, lvl(n, p, f, d));
    end
  endtask

  task automatic dropLow(input string tag);
    pwmIn = 1'b0;
    @(negedge clk);
    chk(tag, pwmOut, 1'b0);
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset", pwmOut, 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", pwmOut, 1'b0);
  endtask

  task automatic t_bypass;
    logic [19:0] pat = 20'b1101_0011_1000_0111_1010;
    setCfg(1'b0, 4, 3, 2);
    for (int i = 0; i < 20; i++) begin
      pwmIn = pat[i];
      @(negedge clk);
      chk("R2 bypass", pwmOut, pat[i]);
    end
    dropLow("R2 bypass end");
  endtask

  task automatic t_basic;
    setCfg(1'b1, 1, 2, 3);
    runHigh("R3/R6 p1 f3 d2", 40, 1, 3, 2);
    dropLow("R7");
    setCfg(1'b1, 3, 6, 2);
    runHigh("R3 p3 f2 d6", 70, 3, 2, 6);
    dropLow("R7");
  endtask

  task automatic t_duty;
    setCfg(1'b1, 2, 7, 1);
    runHigh("R5 duty7", 48, 2, 1, 7);
    dropLow("R7");
    setCfg(1'b1, 1, 0, 2);
    runHigh("R5 duty0", 40, 1, 2, 0);
    dropLow("R7");
  endtask

  task automatic t_clamp;
    setCfg(1'b1, 0, 5, 0);
    runHigh("R4/R6 zero clamp", 24, 1, 1, 5);
    dropLow("R7");
    setCfg(1'b1, 20, 4, 1);
    runHigh("R4 prescale clamp", 200, 16, 1, 4);
    dropLow("R7");
    setCfg(1'b1, 1, 3, 25);
    runHigh("R6 first clamp", 140, 1, 16, 3);
    dropLow("R7");
  endtask

  task automatic t_fallMid;
    setCfg(1'b1, 2, 4, 4);
    runHigh("R6 first pulse", 5, 2, 4, 4);
    dropLow("R7 fall mid first pulse");
    @(negedge clk);
    chk("R7 stays low", pwmOut, 1'b0);
  endtask

  task automatic t_restart;
    setCfg(1'b1, 1, 3, 1);
    runHigh("R8 first phase", 13, 1, 1, 3);
    dropLow("R8 gap");
    runHigh("R8 restarted phase", 12, 1, 1, 3);
    dropLow("R7");
  endtask

  task automatic t_shadow;
    setCfg(1'b1, 1, 2, 1);
    runHigh("R9 before change", 10, 1, 1, 2);
    cfgDuty = 3'd6;  // mid-period write, period 1 ends after n = 15
    for (int n = 10; n < 24; n++) begin
      @(negedge clk);
      chk("R9 shadow timing", pwmOut, (n < 16) ? lvl(n, 1, 1, 2) : lvl(n, 1, 1, 6));
    end
    dropLow("R7");
  endtask

  task automatic t_resetMid;
    setCfg(1'b1, 1, 4, 1);
    pwmIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pre-reset high", pwmOut, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", pwmOut, 1'b0);
    @(negedge clk);
    chk("R1 held in reset", pwmOut, 1'b0);
    pwmIn = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pwmOut, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_basic();
    t_duty();
    t_clamp();
    t_fallMid();
    t_restart();
    t_shadow();
    t_resetMid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule